// File: doc/BRIEF.md
# Stallable Indexed Receive Buffer

This block is the receiving end of a 128-bit beat stream that uses valid, ready and a last marker. Each accepted beat goes into the next free slot of an eight-entry buffer. The first beat lands in slot 0 and the following beats take the slots after it in order. The block keeps a 32-bit count of accepted beats. It also holds a sticky flag that sets once a beat carrying the last marker has been taken in.

An external stall input can pull ready low on any cycle. This lets a test or a system model hold back the sender in the middle of a transfer and then release it, with no beat lost or repeated. Ready also drops when all eight slots are filled. Any stored slot can be read by its index on a separate port, which returns the data one cycle later with a valid strobe. Every accepted beat also produces a one-cycle trace record that gives the slot it was written to and the count after it.

Top module: `beat_slot_sink`

## Requirements
- R1: `s_ready` is high in the same cycle exactly when `stall` is low and fewer than DEPTH (8) beats are stored. A beat is accepted on a rising clock edge when `s_valid` and `s_ready` are both high.
- R2: While `stall` is high, `s_ready` is low and `beat_count` keeps its value across the edge.
- R3: The k-th beat accepted since reset (k counted from 0) is written to slot k. Slot indices run from 0 to 7 on a 3-bit index.
- R4: `beat_count` is 32 bits wide and grows by exactly one for each accepted beat. The new value shows in the cycle after the accepting edge. With no accepted beat, the count does not change.
- R5: `last_seen` rises in the cycle after a beat with `s_last` = 1 is accepted, and stays high until reset. A beat with `s_last` = 1 that is refused does not set it.
- R6: If `rd_req` is high with `rd_idx` = n at an edge, then in the following cycle `rd_valid` is 1 and `rd_data` holds the contents of slot n. In the cycle after an edge without a request, `rd_valid` is 0.
- R7: Once 8 beats are stored, `s_ready` stays low. Offered beats are then neither stored nor counted, and the slots that were already filled keep their contents.
- R8: Reset (`rst_n` = 0, asynchronous) clears the fill level, `beat_count`, `last_seen`, `rd_valid` and `trc_valid`. With `stall` low, `s_ready` is high right after reset, and the next beat goes to slot 0.
- R9: In the cycle after each accepted beat, `trc_valid` is 1, `trc_slot` gives the slot that was written and `trc_count` equals the new `beat_count`. In the cycle after an edge with no accepted beat, `trc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sender offers a beat |
| s_data | input | 128 | Beat payload |
| s_last | input | 1 | Beat is the final one of a transfer |
| s_ready | output | 1 | Block will take the offered beat |
| stall | input | 1 | Forces `s_ready` low |
| rd_req | input | 1 | Read request for one slot |
| rd_idx | input | 3 | Slot index to read |
| rd_data | output | 128 | Slot contents, one cycle after the request |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| beat_count | output | 32 | Number of beats accepted since reset |
| last_seen | output | 1 | Sticky: a beat with the last marker was accepted |
| trc_valid | output | 1 | Trace record for a beat accepted at the previous edge |
| trc_slot | output | 3 | Slot written by the traced beat |
| trc_count | output | 32 | Beat count after the traced beat |

## Verification
The outputs fall into two timing classes.
- **Same cycle (combinational):** `s_ready`. The bench checks it one nanosecond after it drives `stall` and `s_valid` on the falling edge, before the next rising edge.
- **One cycle later (one register stage):** `beat_count`, `last_seen`, the trace fields and the read port all change on the edge that accepts the beat or the request. The bench samples them one nanosecond after that rising edge and compares them with its own model, which it has already advanced for that edge.

Stall and full refusals are checked in the same way. The bench confirms the count, the trace strobe and, later, the slot contents through the read port, so an ignored beat is visible at the ports.

// File: rtl/bcap_pkg.sv
package bcap_pkg;

  localparam int unsigned BCAP_DATA_W = 128;
  localparam int unsigned BCAP_DEPTH  = 8;
  localparam int unsigned BCAP_CNT_W  = 32;

  // Buffer holds as many beats as it has slots.
  function automatic logic bcap_is_full(input int unsigned fill, input int unsigned depth);
    return fill >= depth;
  endfunction

  // Ready rule: no stall and room left.
  function automatic logic bcap_ready(input logic stall_i, input logic full_i);
    return !stall_i && !full_i;
  endfunction

  // Counter step used by fill level and beat count alike.
  function automatic int unsigned bcap_step(input int unsigned v);
    return v + 1;
  endfunction

endpackage

// File: rtl/bcap_admit.sv
module bcap_admit
  import bcap_pkg::*;
#(
  parameter int unsigned DEPTH  = BCAP_DEPTH,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             stall,
  output logic             in_ready,
  output logic             take,
  output logic [IDX_W-1:0] wr_slot,
  output logic             full
);

  logic [FILL_W-1:0] fill_q;

  always_comb begin
    full     = bcap_is_full(32'(fill_q), DEPTH);
    in_ready = bcap_ready(stall, full);
    take     = in_valid && in_ready;
    wr_slot  = fill_q[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (take) begin
      fill_q <= FILL_W'(bcap_step(32'(fill_q)));
    end
  end

endmodule

// File: rtl/bcap_store.sv
module bcap_store
  import bcap_pkg::*;
#(
  parameter int unsigned DATA_W = BCAP_DATA_W,
  parameter int unsigned DEPTH  = BCAP_DEPTH,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [(2**IDX_W)-1:0][DATA_W-1:0] slot_flat;

  // One register bank per slot; contents are not reset.
  for (genvar g = 0; g < (2**IDX_W); g++) begin : g_slot
    if (g < DEPTH) begin : g_live
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (wr_en && (wr_slot == IDX_W'(g))) begin
          q <= wr_data;
        end
      end
      assign slot_flat[g] = q;
    end else begin : g_pad
      assign slot_flat[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req) begin
      rd_data <= slot_flat[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
    end
  end

endmodule

// File: rtl/bcap_tally.sv
module bcap_tally
  import bcap_pkg::*;
#(
  parameter int unsigned CNT_W = BCAP_CNT_W,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             in_last,
  input  logic [IDX_W-1:0] wr_slot,
  output logic [CNT_W-1:0] count,
  output logic             last_seen,
  output logic             trc_valid,
  output logic [IDX_W-1:0] trc_slot,
  output logic [CNT_W-1:0] trc_count
);

  logic [CNT_W-1:0] count_nx;

  always_comb count_nx = CNT_W'(bcap_step(32'(count)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      last_seen <= 1'b0;
      trc_valid <= 1'b0;
      trc_slot  <= '0;
      trc_count <= '0;
    end else begin
      trc_valid <= take;
      if (take) begin
        count     <= count_nx;
        trc_slot  <= wr_slot;
        trc_count <= count_nx;
        if (in_last) begin
          last_seen <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/beat_slot_sink.sv
module beat_slot_sink
  import bcap_pkg::*;
#(
  parameter int unsigned DATA_W = BCAP_DATA_W,
  parameter int unsigned DEPTH  = BCAP_DEPTH,
  parameter int unsigned CNT_W  = BCAP_CNT_W,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              stall,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  beat_count,
  output logic              last_seen,
  output logic              trc_valid,
  output logic [IDX_W-1:0]  trc_slot,
  output logic [CNT_W-1:0]  trc_count
);

  // Named internal events, visible to the bound checker.
  logic             take;
  logic             slot_full;
  logic [IDX_W-1:0] wr_slot;

  bcap_admit #(.DEPTH(DEPTH)) u_admit (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .stall    (stall),
    .in_ready (s_ready),
    .take     (take),
    .wr_slot  (wr_slot),
    .full     (slot_full)
  );

  bcap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (take),
    .wr_slot  (wr_slot),
    .wr_data  (s_data),
    .rd_req   (rd_req),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  bcap_tally #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .in_last   (s_last),
    .wr_slot   (wr_slot),
    .count     (beat_count),
    .last_seen (last_seen),
    .trc_valid (trc_valid),
    .trc_slot  (trc_slot),
    .trc_count (trc_count)
  );

endmodule

// File: rtl/bcap_checks.sv
module bcap_checks #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_last,
  input logic             s_ready,
  input logic             stall,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [CNT_W-1:0] beat_count,
  input logic             last_seen,
  input logic             trc_valid,
  input logic [IDX_W-1:0] trc_slot,
  input logic [IDX_W-1:0] wr_slot,
  input logic [CNT_W-1:0] trc_count,
  input logic             slot_full,
  input logic             take
);

  a_r1_take_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (s_valid && s_ready));

  a_r2_stall_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !s_ready);

  a_r2_stall_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(beat_count));

  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (beat_count == $past(beat_count) + 1'b1));

  a_r4_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(beat_count));

  a_r5_last_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> last_seen);

  a_r5_last_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    last_seen |=> last_seen);

  a_r6_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r6_no_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  a_r7_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |-> !s_ready);

  a_r7_full_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |=> $stable(beat_count));

  a_r9_trace_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (trc_valid && trc_count == beat_count));

  a_r9_trace_slot: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (trc_slot == $past(wr_slot)));

  a_r9_trace_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !trc_valid);

endmodule

bind beat_slot_sink bcap_checks #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_last     (s_last),
  .s_ready    (s_ready),
  .stall      (stall),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .beat_count (beat_count),
  .last_seen  (last_seen),
  .trc_valid  (trc_valid),
  .trc_slot   (trc_slot),
  .wr_slot    (wr_slot),
  .trc_count  (trc_count),
  .slot_full  (slot_full),
  .take       (take)
);

// File: tb/sim_beat_slot_sink.sv
`timescale 1ns/1ps
module sim_beat_slot_sink;

  localparam int NV = 15;

  typedef struct packed {
    logic v;
    logic l;
    logic s;
  } vec_t;

  // valid, last, stall per cycle
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic [127:0] s_data = '0;
  logic         s_last = 1'b0;
  logic         s_ready;
  logic         stall = 1'b0;
  logic         rd_req = 1'b0;
  logic [2:0]   rd_idx = '0;
  logic [127:0] rd_data;
  logic         rd_valid;
  logic [31:0]  beat_count;
  logic         last_seen;
  logic         trc_valid;
  logic [2:0]   trc_slot;
  logic [31:0]  trc_count;

  always #2 clk = ~clk;

  beat_slot_sink u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .stall(stall), .rd_req(rd_req), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .beat_count(beat_count),
    .last_seen(last_seen), .trc_valid(trc_valid), .trc_slot(trc_slot),
    .trc_count(trc_count)
  );

  int nchk = 0;
  int nbad = 0;

  logic [127:0] m_slot [8];
  int           m_fill;
  int           m_cnt;
  logic         m_last;

  function automatic logic [127:0] beat_word(input int j);
    logic [31:0] w;
    w = 32'h5A00_0000 ^ (32'(j) * 32'h0103_0507);
    return {w, ~w, w + 32'd1, 32'(j)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_slot[i] = '0;
    m_fill = 0;
    m_cnt  = 0;
    m_last = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8", "ready after reset", 128'(s_ready), 128'(1));
    chk("R8", "count after reset", 128'(beat_count), 128'(0));
    chk("R8", "last after reset", 128'(last_seen), 128'(0));
    chk("R8", "rd_valid after reset", 128'(rd_valid), 128'(0));
    chk("R8", "trc_valid after reset", 128'(trc_valid), 128'(0));

    // Table walk: stall mid-transfer, resume, fill up, refuse when full.
    for (int j = 0; j < NV; j++) begin
      logic exp_rdy;
      logic tk;
      int   old_fill;
      @(negedge clk);
      s_valid = VEC[j].v;
      s_last  = VEC[j].l;
      stall   = VEC[j].s;
      s_data  = beat_word(j);
      exp_rdy = !VEC[j].s && (m_fill < 8);
      tk      = VEC[j].v && exp_rdy;
      old_fill = m_fill;
      #1;
      chk(VEC[j].s ? "R2" : (m_fill >= 8 ? "R7" : "R1"), "s_ready",
          128'(s_ready), 128'(exp_rdy));
      @(posedge clk);
      if (tk) begin
        m_slot[m_fill] = beat_word(j);
        m_fill++;
        m_cnt++;
        if (VEC[j].l) m_last = 1'b1;
      end
      #1;
      chk(VEC[j].s ? "R2" : (old_fill >= 8 ? "R7" : "R4"), "beat_count",
          128'(beat_count), 128'(m_cnt));
      chk("R5", "last_seen", 128'(last_seen), 128'(m_last));
      chk("R9", "trc_valid", 128'(trc_valid), 128'(tk));
      if (tk) begin
        chk("R9", "trc_slot", 128'(trc_slot), 128'(old_fill));
        chk("R9", "trc_count", 128'(trc_count), 128'(m_cnt));
      end
    end

    // Read back every slot: order and untouched contents after refusals.
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    stall   = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_req = 1'b1;
      rd_idx = 3'(i);
      @(posedge clk);
      #1;
      chk("R6", "rd_valid", 128'(rd_valid), 128'(1));
      chk(i == 7 ? "R7" : "R3", "slot data", rd_data, m_slot[i]);
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(posedge clk);
    #1;
    chk("R6", "rd_valid idle", 128'(rd_valid), 128'(0));
    chk("R7", "ready while full", 128'(s_ready), 128'(0));

    // Reset mid-run, then the next beat must land in slot 0.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", "count in reset", 128'(beat_count), 128'(0));
    chk("R8", "last in reset", 128'(last_seen), 128'(0));
    chk("R8", "ready in reset", 128'(s_ready), 128'(1));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    s_valid = 1'b1;
    s_last  = 1'b0;
    s_data  = beat_word(99);
    @(posedge clk);
    #1;
    chk("R3", "slot after reset", 128'(trc_slot), 128'(0));
    chk("R4", "count after reset beat", 128'(beat_count), 128'(1));
    chk("R5", "last stays clear", 128'(last_seen), 128'(0));
    @(negedge clk);
    s_valid = 1'b0;
    rd_req  = 1'b1;
    rd_idx  = 3'd0;
    @(posedge clk);
    #1;
    chk("R3", "slot0 new data", rd_data, beat_word(99));
    chk("R6", "rd_valid", 128'(rd_valid), 128'(1));
    @(negedge clk);
    rd_req = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule